// File: doc/BRIEF.md
# Processor-Side Peripheral Register Port

This block lets the local processor reach the card's control registers, status bits and general-purpose ports through its I/O space. An 11-bit I/O address is split into two parts. The upper seven bits select this block against a base value fixed by a parameter. The lower four bits pick one of sixteen register slots. An access counts only while the I/O select strobe is high. A read or write strobe then sets the direction of the 16-bit transfer. Reads return data in the same cycle and writes take effect at the next clock edge, so no access ever waits.

The control register drives the interrupt request level towards the host and enables the ring-detect interrupt. A status register holds two pending interrupt flags for the processor. One flag is set by a rising edge on the asynchronous ring input while the enable is set. The other is set by a one-cycle trigger from the host side. Both flags stay set until the processor writes a one to them. A port-out register drives a 16-bit output, and a port-in slot reads a 16-bit input.

Top module: `iop_regport`

## Requirements
- R1: An access takes effect only when addr[10:4] equals the BASE parameter (default 0). Outside that window a write changes nothing, and a read gives rdata_oe=0 and rdata=0. addr[3:0] is the register index.
- R2: While io_sel is low, no register changes and rdata_oe stays low, whatever the other strobes do.
- R3: During a valid read (io_sel=1, rd_en=1, wr_en=0, base match), rdata_oe is high and rdata carries the register value in that same cycle. At all other times rdata is 0.
- R4: Index 0 is the control register. Bit 0 drives host_irq. Bit 1 is the ring interrupt enable. Bits 15:2 read as 0.
- R5: Indices 4 to 15 are not implemented. They read 0, with rdata_oe high, and writes to them have no effect.
- R6: A rising edge on ring_in with the enable set raises proc_ring_irq and status bit 0. With the default two-stage synchronizer this happens at the third clock edge after the change.
- R7: A rising edge on ring_in while the enable is 0 leaves proc_ring_irq low. A level that stays high raises no further events.
- R8: host_swi_set high at a clock edge sets status bit 1 and proc_swi_irq at that edge. The flag then holds until it is cleared.
- R9: Status is index 1 and is write-one-to-clear: a 1 in bit 0 or bit 1 clears that flag, and a 0 leaves it alone. If a set and a clear of the same flag meet in one cycle, the set wins.
- R10: Index 2 is a read/write register that drives port_out. Index 3 reads port_in.
- R11: After reset, host_irq, proc_ring_irq, proc_swi_irq and port_out are 0, and the control register reads 0.
- R12: If rd_en and wr_en are both high in a valid cycle, the cycle is a write, and rdata_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | I/O space select strobe, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 11 | Block base [10:4], register index [3:0] |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data valid / drive enable |
| port_in | input | 16 | General-purpose input port |
| port_out | output | 16 | General-purpose output port |
| ring_in | input | 1 | Asynchronous ring-detect input |
| host_swi_set | input | 1 | One-cycle interrupt trigger from the host |
| host_irq | output | 1 | Interrupt request level to the host |
| proc_ring_irq | output | 1 | Ring interrupt to the processor |
| proc_swi_irq | output | 1 | Host-triggered interrupt to the processor |

## Verification
A wrong decode state shows up at once on rdata_oe and rdata in the cycle of the access. A write that lands in the wrong slot shows on port_out or host_irq one edge later. A fault in the synchronizer or the edge detector moves the rise of proc_ring_irq away from the third edge after the change, or repeats it while the input is held high, so the bench checks that cycle exactly. Errors in the write-one-to-clear logic or the set-wins rule show on the interrupt pins one edge after the colliding cycle.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned BASE_W = ADDR_W - IDX_W;

  localparam logic [IDX_W-1:0] IDX_CTRL     = 4'd0;
  localparam logic [IDX_W-1:0] IDX_STAT     = 4'd1;
  localparam logic [IDX_W-1:0] IDX_PORT_OUT = 4'd2;
  localparam logic [IDX_W-1:0] IDX_PORT_IN  = 4'd3;

  localparam int unsigned CTRL_HOST_IRQ = 0;
  localparam int unsigned CTRL_RING_EN  = 1;
  localparam int unsigned STAT_RING     = 0;
  localparam int unsigned STAT_SWI      = 1;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [IDX_W-1:0] idx;
  } acc_t;
endpackage

// File: rtl/iop_addr_decode.sv
module iop_addr_decode
  import iop_pkg::*;
#(
  parameter logic [BASE_W-1:0] BASE = '0
) (
  input  logic              io_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  logic hit;

  always_comb begin
    hit     = (addr[ADDR_W-1:IDX_W] == BASE);
    acc.wr  = io_sel & wr_en & hit;
    acc.rd  = io_sel & rd_en & ~wr_en & hit;
    acc.idx = addr[IDX_W-1:0];
  end
endmodule

// File: rtl/iop_ctrl_regs.sv
module iop_ctrl_regs
  import iop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic [DATA_W-1:0] wdata,
  output logic              host_irq,
  output logic              ring_en,
  output logic [DATA_W-1:0] port_out
);
  logic              ctrl_en, port_en;
  logic              host_irq_nxt, ring_en_nxt;
  logic [DATA_W-1:0] port_nxt;

  always_comb begin
    ctrl_en      = acc.wr && (acc.idx == IDX_CTRL);
    port_en      = acc.wr && (acc.idx == IDX_PORT_OUT);
    host_irq_nxt = wdata[CTRL_HOST_IRQ];
    ring_en_nxt  = wdata[CTRL_RING_EN];
    port_nxt     = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_irq <= 1'b0;
      ring_en  <= 1'b0;
    end else if (ctrl_en) begin
      host_irq <= host_irq_nxt;
      ring_en  <= ring_en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_out <= '0;
    else if (port_en) port_out <= port_nxt;
  end

  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr && acc.idx == IDX_CTRL) |=> (host_irq == $past(wdata[CTRL_HOST_IRQ])))
    else $error("control write not taken");
endmodule

// File: rtl/iop_irq_status.sv
module iop_irq_status #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ring_in,
  input  logic       ring_en,
  input  logic       swi_set,
  input  logic       clr_en,
  input  logic [1:0] clr_mask,
  output logic       ring_pend,
  output logic       swi_pend
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_nxt;
  logic ring_d;
  logic ring_rise;
  logic ring_pend_nxt, swi_pend_nxt;
  logic pend_en;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_nxt = ring_in;
    end else begin : g_chain
      always_comb sync_nxt = {sync_q[SYNC_STAGES-2:0], ring_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      ring_d <= 1'b0;
    end else begin
      sync_q <= sync_nxt;
      ring_d <= sync_q[LAST];
    end
  end

  always_comb begin
    ring_rise     = sync_q[LAST] & ~ring_d;
    pend_en       = clr_en | ring_rise | swi_set;
    ring_pend_nxt = ring_pend;
    swi_pend_nxt  = swi_pend;
    if (clr_en && clr_mask[0]) ring_pend_nxt = 1'b0;
    if (clr_en && clr_mask[1]) swi_pend_nxt  = 1'b0;
    if (ring_rise && ring_en)  ring_pend_nxt = 1'b1;
    if (swi_set)               swi_pend_nxt  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_pend <= 1'b0;
      swi_pend  <= 1'b0;
    end else if (pend_en) begin
      ring_pend <= ring_pend_nxt;
      swi_pend  <= swi_pend_nxt;
    end
  end

  assert_ring_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_pend) |-> $past(ring_en))
    else $error("ring flag set while disabled");

  assert_swi_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swi_set |=> swi_pend)
    else $error("host trigger lost");

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mask[1] && !swi_set) |=> !swi_pend)
    else $error("write-one-to-clear failed");
endmodule

// File: rtl/iop_regport.sv
module iop_regport
  import iop_pkg::*;
#(
  parameter logic [BASE_W-1:0] BASE        = '0,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] port_out,
  input  logic              ring_in,
  input  logic              host_swi_set,
  output logic              host_irq,
  output logic              proc_ring_irq,
  output logic              proc_swi_irq
);
  acc_t acc;
  logic ring_en;
  logic stat_clr;
  logic [DATA_W-1:0] rd_mux;

  iop_addr_decode #(.BASE(BASE)) u_dec (
    .io_sel(io_sel), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .acc(acc)
  );

  iop_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(wdata),
    .host_irq(host_irq), .ring_en(ring_en), .port_out(port_out)
  );

  always_comb stat_clr = acc.wr && (acc.idx == IDX_STAT);

  iop_irq_status #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .ring_en(ring_en),
    .swi_set(host_swi_set), .clr_en(stat_clr), .clr_mask(wdata[1:0]),
    .ring_pend(proc_ring_irq), .swi_pend(proc_swi_irq)
  );

  always_comb begin
    rd_mux = '0;
    if (acc.rd) begin
      case (acc.idx)
        IDX_CTRL: begin
          rd_mux[CTRL_HOST_IRQ] = host_irq;
          rd_mux[CTRL_RING_EN]  = ring_en;
        end
        IDX_STAT: begin
          rd_mux[STAT_RING] = proc_ring_irq;
          rd_mux[STAT_SWI]  = proc_swi_irq;
        end
        IDX_PORT_OUT: rd_mux = port_out;
        IDX_PORT_IN:  rd_mux = port_in;
        default:      rd_mux = '0;
      endcase
    end
    rdata    = rd_mux;
    rdata_oe = acc.rd;
  end

  assert_nosel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel |=> ($stable(port_out) && $stable(host_irq)))
    else $error("register changed without select");

  assert_offbase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:IDX_W] != BASE) |=> $stable(port_out))
    else $error("write outside base window");

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0))
    else $error("read data driven while idle");
endmodule

// File: tb/iop_regport_test.sv
module iop_regport_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_sel, rd_en, wr_en;
  logic [10:0] addr;
  logic [15:0] wdata, rdata, port_in, port_out;
  logic        rdata_oe, ring_in, host_swi_set;
  logic        host_irq, proc_ring_irq, proc_swi_irq;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  iop_regport uut (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .port_in(port_in), .port_out(port_out), .ring_in(ring_in),
    .host_swi_set(host_swi_set), .host_irq(host_irq),
    .proc_ring_irq(proc_ring_irq), .proc_swi_irq(proc_swi_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [15:0] d, input logic sel);
    @(negedge clk);
    io_sel = sel; wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    io_sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [10:0] a, input logic sel,
                          output logic [15:0] d, output logic oe);
    @(negedge clk);
    io_sel = sel; rd_en = 1'b1; wr_en = 1'b0; addr = a;
    #1;
    d = rdata; oe = rdata_oe;
    io_sel = 1'b0; rd_en = 1'b0; addr = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic oe;
    check("R11 host_irq", {15'b0, host_irq}, 16'h0);
    check("R11 ring irq", {15'b0, proc_ring_irq}, 16'h0);
    check("R11 swi irq", {15'b0, proc_swi_irq}, 16'h0);
    check("R11 port_out", port_out, 16'h0);
    bus_read(11'h000, 1'b1, d, oe);
    check("R11 ctrl read", d, 16'h0);
    check("R3 idle rdata", rdata, 16'h0);
  endtask

  task automatic t_ctrl();
    logic [15:0] d; logic oe;
    bus_write(11'h000, 16'hFFFD, 1'b1);
    check("R4 host_irq set", {15'b0, host_irq}, 16'h1);
    bus_read(11'h000, 1'b1, d, oe);
    check("R4 ctrl readback", d, 16'h0001);
    check("R3 read oe", {15'b0, oe}, 16'h1);
    bus_write(11'h000, 16'h0002, 1'b1);
    check("R4 host_irq clr", {15'b0, host_irq}, 16'h0);
    bus_read(11'h000, 1'b1, d, oe);
    check("R4 ring_en readback", d, 16'h0002);
    bus_write(11'h000, 16'h0000, 1'b1);
  endtask

  task automatic t_decode();
    logic [15:0] d; logic oe;
    bus_write(11'h012, 16'h5555, 1'b1);
    check("R1 off-base write", port_out, 16'h0);
    bus_read(11'h010, 1'b1, d, oe);
    check("R1 off-base oe", {15'b0, oe}, 16'h0);
    check("R1 off-base data", d, 16'h0);
    bus_write(11'h002, 16'h7777, 1'b0);
    check("R2 no-select write", port_out, 16'h0);
    bus_read(11'h002, 1'b0, d, oe);
    check("R2 no-select oe", {15'b0, oe}, 16'h0);
  endtask

  task automatic t_unimpl();
    logic [15:0] d; logic oe;
    bus_write(11'h007, 16'hBEEF, 1'b1);
    bus_read(11'h007, 1'b1, d, oe);
    check("R5 unimpl data", d, 16'h0);
    check("R5 unimpl oe", {15'b0, oe}, 16'h1);
    bus_read(11'h00F, 1'b1, d, oe);
    check("R5 index 15", d, 16'h0);
  endtask

  task automatic t_port();
    logic [15:0] d; logic oe;
    bus_write(11'h002, 16'hA5C3, 1'b1);
    check("R10 port_out", port_out, 16'hA5C3);
    bus_read(11'h002, 1'b1, d, oe);
    check("R10 port_out read", d, 16'hA5C3);
    port_in = 16'h1234;
    bus_read(11'h003, 1'b1, d, oe);
    check("R10 port_in read", d, 16'h1234);
    @(negedge clk);
    io_sel = 1'b1; rd_en = 1'b1; wr_en = 1'b1; addr = 11'h002; wdata = 16'h0F0F;
    #1;
    check("R12 both oe", {15'b0, rdata_oe}, 16'h0);
    @(negedge clk);
    io_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    check("R12 both writes", port_out, 16'h0F0F);
  endtask

  task automatic t_ring();
    logic [15:0] d; logic oe;
    @(negedge clk); ring_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 disabled ring", {15'b0, proc_ring_irq}, 16'h0);
    ring_in = 1'b0;
    repeat (4) @(negedge clk);
    bus_write(11'h000, 16'h0002, 1'b1);
    ring_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 not before third edge", {15'b0, proc_ring_irq}, 16'h0);
    @(negedge clk);
    check("R6 ring irq at third edge", {15'b0, proc_ring_irq}, 16'h1);
    bus_read(11'h001, 1'b1, d, oe);
    check("R6 status bit0", d, 16'h0001);
    bus_write(11'h001, 16'h0002, 1'b1);
    check("R9 zero leaves flag", {15'b0, proc_ring_irq}, 16'h1);
    bus_write(11'h001, 16'h0001, 1'b1);
    check("R9 one clears flag", {15'b0, proc_ring_irq}, 16'h0);
    repeat (4) @(negedge clk);
    check("R7 held level no event", {15'b0, proc_ring_irq}, 16'h0);
    ring_in = 1'b0;
  endtask

  task automatic t_swi();
    logic [15:0] d; logic oe;
    @(negedge clk); host_swi_set = 1'b1;
    @(negedge clk); host_swi_set = 1'b0;
    check("R8 swi set", {15'b0, proc_swi_irq}, 16'h1);
    repeat (3) @(negedge clk);
    check("R8 swi held", {15'b0, proc_swi_irq}, 16'h1);
    bus_read(11'h001, 1'b1, d, oe);
    check("R8 status bit1", d, 16'h0002);
    @(negedge clk);
    host_swi_set = 1'b1; io_sel = 1'b1; wr_en = 1'b1; addr = 11'h001; wdata = 16'h0002;
    @(negedge clk);
    host_swi_set = 1'b0; io_sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    check("R9 set wins", {15'b0, proc_swi_irq}, 16'h1);
    bus_write(11'h001, 16'h0002, 1'b1);
    check("R9 swi cleared", {15'b0, proc_swi_irq}, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; io_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0; port_in = '0; ring_in = 1'b0; host_swi_set = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_decode();
    t_unimpl();
    t_port();
    t_ring();
    t_swi();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule